// File: doc/BRIEF.md
# External Interrupt Line Conditioner

The conditioner sits between external interrupt pins and a downstream interrupt controller. That controller accepts only active-high levels or rising edges. Each pin is first synchronised into the core clock domain. Software then sets, for each pin, whether it is sensed as a level or as an edge and which polarity it uses. The block inverts active-low and falling-edge pins so that every output has a single, uniform meaning. A per-line enable masks the output.

Configuration goes through a small single-cycle, 32-bit word bus. Word 0 is a free scratch word for software. Word 1 + n holds the settings of line n. Reads are combinational and show the current register contents. In edge mode the block emits a one-cycle pulse for each qualifying edge. When a line's settings are rewritten, its edge history is refreshed, so a change of polarity does not turn into a spurious pulse.

Top module: `xint_conditioner`

## Requirements
- R1: After a synchronous reset every register reads zero and every output is low, so all lines start disabled and set to rising edge.
- R2: The settings word of line n sits at byte address 4 + 4n. Bit 16 is enable, bit 9 is level sense (1 = level, 0 = edge) and bit 8 is polarity. All other bits ignore writes and read as zero.
- R3: The word at address 0 stores and returns all 32 bits. Any other address reads zero, and writes to it change no register.
- R4: Each pin passes two synchroniser flops. A pin change driven before clock edge k shows on the output from edge k+1 on, and not before.
- R5: With level = 1 and polarity = 1 the output equals the synchronised pin.
- R6: With level = 1 and polarity = 0 the output equals the inverted synchronised pin.
- R7: With level = 0 and polarity = 0, each rising pin edge gives exactly one output cycle high.
- R8: With level = 0 and polarity = 1, each falling pin edge gives exactly one output cycle high.
- R9: A line whose enable bit is 0 holds its output low.
- R10: In the cycle after a write to a line's settings word, that line raises no edge pulse, and its edge history takes the newly corrected pin value.
- R11: The two lines act independently: a pin or settings change on one line never alters the other line's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle |
| pins | input | 2 | Raw external interrupt pins |
| irq_out | output | 2 | Conditioned active-high / rising-edge requests |

## Verification
The main corner case is a polarity flip on an edge line whose pin is steady. A design that kept its edge history across the write would emit a false pulse in the cycle after the write. A second target is synchroniser latency: one flop too few makes the output move a cycle early, and one too many makes it move a cycle late. The bench also writes all-ones to the settings words and touches the unmapped address. A design that decoded too wide or kept stray bits would then read back nonzero data or change a line's mode. Random pin traffic with random rewrites checks that every edge pulse lasts one cycle and that one line never disturbs the other.

// File: rtl/xint_pkg.sv
// Shared field positions and per-line settings type for the conditioner.
// Assumes a bus word of at least 17 bits so that the enable bit fits.
package xint_pkg;
    localparam int EN_BIT  = 16;
    localparam int LVL_BIT = 9;
    localparam int POL_BIT = 8;

    typedef struct packed {
        logic en;
        logic lvl;
        logic pol;
    } line_cfg_t;
endpackage

// File: rtl/xint_regs.sv
// Register file: one scratch word at word 0 and a settings word per line at
// word 1 + n. Reads are combinational; writes land on the clock edge.
// Also emits a one-cycle update strobe per line in the cycle after its write.
// Assumes NUM_LINES + 1 words fit in the address range.
module xint_regs
    import xint_pkg::*;
#(
    parameter int NUM_LINES = 2,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_sel,
    input  logic                            bus_wr,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [DATA_W-1:0]               bus_wdata,
    output logic [DATA_W-1:0]               bus_rdata,
    output line_cfg_t [NUM_LINES-1:0]       cfg_o,
    output logic [NUM_LINES-1:0]            upd_o
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word_idx;
    logic              aligned;
    logic [DATA_W-1:0] scratch_q;

    assign word_idx = bus_addr[ADDR_W-1:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);

    // Scratch word: plain storage at word 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            scratch_q <= '0;
        else if (bus_sel && bus_wr && aligned && word_idx == '0)
            scratch_q <= bus_wdata;
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic hit;
        assign hit = bus_sel && bus_wr && aligned && (word_idx == WORD_W'(g + 1));

        // Settings word of line g; only the three defined bits are stored.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_o[g] <= '0;
                upd_o[g] <= 1'b0;
            end else begin
                upd_o[g] <= hit;
                if (hit) begin
                    cfg_o[g].en  <= bus_wdata[EN_BIT];
                    cfg_o[g].lvl <= bus_wdata[LVL_BIT];
                    cfg_o[g].pol <= bus_wdata[POL_BIT];
                end
            end
        end
    end

    // Read mux: unmapped or misaligned words return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && aligned) begin
            if (word_idx == '0)
                bus_rdata = scratch_q;
            for (int i = 0; i < NUM_LINES; i++) begin
                if (word_idx == WORD_W'(i + 1)) begin
                    bus_rdata[EN_BIT]  = cfg_o[i].en;
                    bus_rdata[LVL_BIT] = cfg_o[i].lvl;
                    bus_rdata[POL_BIT] = cfg_o[i].pol;
                end
            end
        end
    end
endmodule

// File: rtl/xint_sync.sv
// Multi-flop synchroniser for a vector of asynchronous pins.
// Assumes STAGES >= 2 and that each pin is independent (no bus coherence).
module xint_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    // Shift the pins through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= d_in;
            for (int s = 1; s < STAGES; s++)
                stg_q[s] <= stg_q[s-1];
        end
    end

    assign q_out = stg_q[STAGES-1];
endmodule

// File: rtl/xint_shaper.sv
// Per-line polarity correction, edge detection and masking.
// Level mode passes the corrected level through; edge mode pulses one cycle
// on a rising corrected value. The update strobe refreshes the edge history
// without pulsing. Assumes sync_in is already in the clock domain.
module xint_shaper
    import xint_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  line_cfg_t cfg,
    input  logic      upd,
    input  logic      sync_in,
    output logic      irq
);
    logic invert;
    logic corr;
    logic prev_q;
    logic pulse;

    // Level wants pol=1 as active-high; edge wants pol=1 as falling.
    assign invert = cfg.lvl ? ~cfg.pol : cfg.pol;
    assign corr   = sync_in ^ invert;
    assign pulse  = corr & ~prev_q & ~upd;

    // Edge history: last corrected value under the settings in force.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else
            prev_q <= corr;
    end

    assign irq = cfg.en & (cfg.lvl ? corr : pulse);
endmodule

// File: rtl/xint_conditioner.sv
// Top: register file, pin synchroniser and one shaper per line.
// Assumes pins are asynchronous and the bus is synchronous to clk.
module xint_conditioner
    import xint_pkg::*;
#(
    parameter int NUM_LINES   = 2,
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_LINES-1:0] pins,
    output logic [NUM_LINES-1:0] irq_out
);
    line_cfg_t [NUM_LINES-1:0] cfg_w;
    logic [NUM_LINES-1:0]      upd_w;
    logic [NUM_LINES-1:0]      sync_w;
    logic [NUM_LINES-1:0]      cfg_en_v;
    logic [NUM_LINES-1:0]      cfg_lvl_v;
    logic [NUM_LINES-1:0]      cfg_pol_v;

    xint_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg_o     (cfg_w),
        .upd_o     (upd_w)
    );

    xint_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pins),
        .q_out (sync_w)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_shp
        assign cfg_en_v[g]  = cfg_w[g].en;
        assign cfg_lvl_v[g] = cfg_w[g].lvl;
        assign cfg_pol_v[g] = cfg_w[g].pol;

        xint_shaper u_shp (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg     (cfg_w[g]),
            .upd     (upd_w[g]),
            .sync_in (sync_w[g]),
            .irq     (irq_out[g])
        );
    end
endmodule

// File: rtl/xint_checker.sv
// Temporal checks on the conditioner, bound to every instance of the top.
// Pin-latency checks are built only for the two-flop synchroniser.
module xint_checker #(
    parameter int NUM_LINES   = 2,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_sel,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [NUM_LINES-1:0] pins,
    input logic [NUM_LINES-1:0] irq_out,
    input logic [NUM_LINES-1:0] cfg_en_v,
    input logic [NUM_LINES-1:0] cfg_lvl_v,
    input logic [NUM_LINES-1:0] cfg_pol_v
);
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_out & ~cfg_en_v) == '0)); // R9

    AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_out & ~cfg_lvl_v & $past(irq_out & ~cfg_lvl_v)) == '0)); // R7

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
        AST_NO_FALSE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(bus_sel && bus_wr && bus_addr == ADDR_W'(4 * (g + 1)))
             && !cfg_lvl_v[g]) |-> !irq_out[g]); // R10

        if (SYNC_STAGES == 2) begin : g_two
            AST_LEVEL_TRACKS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_en_v[g] && cfg_lvl_v[g])
                |-> (irq_out[g] == ($past(pins[g], 2) ^ !cfg_pol_v[g]))); // R5

            AST_EDGE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
                (irq_out[g] && !cfg_lvl_v[g])
                |-> ($past(pins[g], 2) != $past(pins[g], 3))); // R8
        end
    end
endmodule

bind xint_conditioner xint_checker #(
    .NUM_LINES   (NUM_LINES),
    .ADDR_W      (ADDR_W),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .pins      (pins),
    .irq_out   (irq_out),
    .cfg_en_v  (cfg_en_v),
    .cfg_lvl_v (cfg_lvl_v),
    .cfg_pol_v (cfg_pol_v)
);

// File: tb/sim_xint_conditioner.sv
module sim_xint_conditioner;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  pins = '0;
    logic [1:0]  irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xint_conditioner u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pins(pins), .irq_out(irq_out)
    );

    // Reference model built from the requirements.
    logic [31:0] m_scr;
    logic [2:0]  m_cfg [NL];   // {en, lvl, pol}
    logic [1:0]  m_s1, m_s2, m_prev, m_upd;

    function automatic logic m_corr(int i);
        logic inv = m_cfg[i][1] ? ~m_cfg[i][0] : m_cfg[i][0];
        return m_s2[i] ^ inv;
    endfunction

    function automatic logic [1:0] m_irq();
        logic [1:0] r;
        for (int i = 0; i < NL; i++)
            r[i] = m_cfg[i][2] & (m_cfg[i][1] ? m_corr(i)
                                              : (m_corr(i) & ~m_prev[i] & ~m_upd[i]));
        return r;
    endfunction

    function automatic logic [31:0] m_read(logic [3:0] a);
        logic [31:0] r = '0;
        if (a == 4'h0) r = m_scr;
        for (int i = 0; i < NL; i++)
            if (a == 4'(4 * (i + 1))) begin
                r[16] = m_cfg[i][2]; r[9] = m_cfg[i][1]; r[8] = m_cfg[i][0];
            end
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_scr <= '0; m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_upd <= '0;
            for (int i = 0; i < NL; i++) m_cfg[i] <= '0;
        end else begin
            m_s1 <= pins;
            m_s2 <= m_s1;
            for (int i = 0; i < NL; i++) begin
                m_prev[i] <= m_corr(i);
                m_upd[i]  <= bus_sel && bus_wr && bus_addr == 4'(4 * (i + 1));
                if (bus_sel && bus_wr && bus_addr == 4'(4 * (i + 1)))
                    m_cfg[i] <= {bus_wdata[16], bus_wdata[9], bus_wdata[8]};
            end
            if (bus_sel && bus_wr && bus_addr == 4'h0) m_scr <= bus_wdata;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [3:0] a, logic [31:0] exp);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: reset state
        chk("R1 irq", 32'(irq_out), 32'h0);
        rd_chk("R1 scratch", 4'h0, 32'h0);
        rd_chk("R1 line0", 4'h4, 32'h0);
        rd_chk("R1 line1", 4'h8, 32'h0);
        // R2 / R3: field masking, scratch, unmapped
        wr(4'h4, 32'hFFFF_FFFF);
        rd_chk("R2 field mask", 4'h4, 32'h0001_0300);
        wr(4'h4, 32'h0);
        wr(4'h0, 32'hA5C3_0FF1);
        rd_chk("R3 scratch", 4'h0, 32'hA5C3_0FF1);
        wr(4'hC, 32'hFFFF_FFFF);
        rd_chk("R3 unmapped read", 4'hC, 32'h0);
        rd_chk("R3 unmapped no effect", 4'h8, 32'h0);
        // R4 / R7: rising edge, latency and one-cycle pulse
        wr(4'h4, 32'h0001_0000);
        step(); step();
        pins[0] = 1'b1;
        step(); chk("R4 latency", 32'(irq_out[0]), 32'h0);
        step(); chk("R7 pulse", 32'(irq_out[0]), 32'h1);
        step(); chk("R7 one cycle", 32'(irq_out[0]), 32'h0);
        // R8: falling edge
        wr(4'h4, 32'h0001_0100);
        step(); step();
        pins[0] = 1'b0;
        step(); chk("R8 latency", 32'(irq_out[0]), 32'h0);
        step(); chk("R8 pulse", 32'(irq_out[0]), 32'h1);
        step(); chk("R8 one cycle", 32'(irq_out[0]), 32'h0);
        // R5: level high
        wr(4'h4, 32'h0001_0300);
        chk("R5 low", 32'(irq_out[0]), 32'h0);
        pins[0] = 1'b1;
        step(); step(); chk("R5 follow", 32'(irq_out[0]), 32'h1);
        // R6: level low
        wr(4'h4, 32'h0001_0200);
        chk("R6 inactive", 32'(irq_out[0]), 32'h0);
        pins[0] = 1'b0;
        step(); step(); chk("R6 active", 32'(irq_out[0]), 32'h1);
        // R9: disabled line is quiet
        wr(4'h4, 32'h0000_0200);
        chk("R9 masked", 32'(irq_out[0]), 32'h0);
        // R10: polarity flip with steady pin gives no pulse
        wr(4'h4, 32'h0001_0000);
        step(); step();
        wr(4'h4, 32'h0001_0100);
        chk("R10 update cycle", 32'(irq_out[0]), 32'h0);
        step(); chk("R10 after", 32'(irq_out[0]), 32'h0);
        // R11: line1 level high leaves line0 alone
        wr(4'h8, 32'h0001_0300);
        pins[1] = 1'b1;
        step(); step(); chk("R11 independence", 32'(irq_out), 32'h2);

        // Random traffic against the model.
        for (int c = 0; c < 3000; c++) begin
            logic [3:0] a;
            chk("R5 R6 R7 R8 R11 random irq", 32'(irq_out), 32'(m_irq()));
            if (bus_sel && !bus_wr)
                chk("R2 R3 random read", bus_rdata, m_read(bus_addr));
            pins = 2'($urandom);
            a = 4'(4 * ($urandom % 4));
            bus_addr = a;
            bus_sel = ($urandom % 3) == 0;
            bus_wr = bus_sel && (($urandom % 4) == 0);
            bus_wdata = $urandom | (($urandom % 2) ? 32'h0001_0000 : 32'h0);
            #1;
            step();
        end
        bus_sel = 1'b0; bus_wr = 1'b0;
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule